// File: doc/BRIEF.md
# Dual-Channel Fast/Slow PWM Generator

The block drives two pulse-width-modulated output pins, A and B, from a single free-running 16-bit up-counter. The counter advances on a count enable taken from a power-of-two prescaler on the system clock, or from rising edges of an external clock pin. After reset it advances once every two system clocks.

Each channel takes an 8-bit timebase from the shared counter. In fast mode this is the low byte. In slow mode it is bits [14:7], which makes the period 128 times longer. The channel drives its pin high while the timebase is below its duty value. A newly written duty value is held back until the timebase returns to zero, so a period is never cut short or stretched.

Software reaches the block through a small register bus with combinational reads. The counter can be read at any time without effect on its value. It can be loaded only while the freeze/test input is high.

Top module: `pwm2_gen`

## Requirements
- R1: After reset the counter reads 0x0000, the duty word reads 0x0000, the control word reads 0x0000 and both pins are low.
- R2: With the reset value of the control word, the counter advances by exactly one every two system clocks.
- R3: Prescaler select code k in 0..6 (control bits [4:2]) makes the counter advance once every 2^(k+1) system clocks.
- R4: Select code 7 makes the counter advance once for each rising edge of the external clock pin. The pin passes through a two-flop synchronizer and an edge detector first.
- R5: With its mode bit clear (fast), a channel's pin is high exactly when counter bits [7:0] are below the channel's active duty value.
- R6: With its mode bit set (slow), a channel's pin is high exactly when counter bits [14:7] are below the active duty value. Mode bit for A is control bit 0 and for B is control bit 1.
- R7: A duty of 0x00 keeps the pin always low. A duty of 0xFF keeps the pin high except when the timebase is 0xFF. A duty of 0x80 gives the first half of each period high.
- R8: A written duty value becomes active only in cycles where the channel's timebase is zero. Until then the old value stays in force.
- R9: The duty word is at address 1, with A in bits [15:8] and B in bits [7:0]. Each byte is written only when its byte enable (bit 1 for the upper byte, bit 0 for the lower byte) is set, and the word reads back as written.
- R10: Address 0 reads the whole counter without changing it. A write to address 0 loads the counter (by byte enable) only while the freeze input is high, and is ignored otherwise.
- R11: The control word at address 2 (byte 0) reads back as written. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count clock pin, asynchronous |
| frz_i | input | 1 | Freeze/test mode; enables counter loads |
| bus_addr_i | input | 2 | Register address: 0 counter, 1 duty, 2 control |
| bus_wr_i | input | 1 | Write strobe, one write per asserted cycle |
| bus_be_i | input | 2 | Byte enables for the write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register, combinational |
| pwm_a_o | output | 1 | Channel A PWM pin |
| pwm_b_o | output | 1 | Channel B PWM pin |

## Verification
Assertions check on every cycle the properties that do not depend on the scenario. Outside a freeze load, the counter either holds or steps by one. The active duty holds whenever the timebase is nonzero. A pin rises only at a timebase of zero. A zero duty gives a low pin at the wrap. An external edge pulse lasts one cycle.

Only the bench scenarios can show the exact count rate for each prescaler code, the pin waveform against an arithmetic model in both modes and for the extreme duty values, the deferred duty update, and the byte-lane and freeze behaviour of bus writes.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
   typedef enum logic [1:0] {
      ADR_CNT  = 2'd0,
      ADR_DUTY = 2'd1,
      ADR_CTRL = 2'd2,
      ADR_NONE = 2'd3
   } pwm2_addr_e;

   localparam int LANE_W = 8;
endpackage

// File: rtl/pwm2_tick.sv
module pwm2_tick #(
   parameter int PRE_STAGES  = 7,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             ext_i,
   output logic             tick_o
);
   localparam int N_TAP = PRE_STAGES + 1;

   if ((1 << SEL_W) != N_TAP) begin : g_bad_sel
      $error("pwm2_tick: select width must cover prescaler taps plus external input");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwm2_tick: synchronizer needs at least two stages");
   end

   logic [PRE_STAGES-1:0]  div_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   ext_edge;
   logic [N_TAP-1:0]       taps;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q  <= '0;
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         div_q  <= div_q + 1'b1;
         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ext_edge = sync_q[SYNC_STAGES-1] & ~prev_q;

   for (genvar k = 0; k < PRE_STAGES; k++) begin : g_tap
      assign taps[k] = &div_q[k:0];
   end
   assign taps[N_TAP-1] = ext_edge;

   assign tick_o = taps[sel_i];

   // R4: an external edge yields a single-cycle enable
   a_r4_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_edge |=> !ext_edge);

   // R3: the divide-by-2 tap never fires on two consecutive cycles
   a_r3_div2_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
      taps[0] |=> !taps[0]);
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan #(
   parameter int DUTY_W   = 8,
   parameter int SLOW_LSB = 7,
   parameter int TB_SRC_W = SLOW_LSB + DUTY_W
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [TB_SRC_W-1:0] cnt_i,
   input  logic                slow_i,
   input  logic [DUTY_W-1:0]   duty_i,
   output logic [DUTY_W-1:0]   tb_o,
   output logic                pwm_o
);
   if (SLOW_LSB >= DUTY_W) begin : g_bad_lsb
      $error("pwm2_chan: slow slice must overlap the fast slice");
   end

   logic [DUTY_W-1:0] act_q;
   logic [DUTY_W-1:0] eff;
   logic              wrap;

   assign tb_o  = slow_i ? cnt_i[SLOW_LSB +: DUTY_W] : cnt_i[DUTY_W-1:0];
   assign wrap  = (tb_o == '0);
   assign eff   = wrap ? duty_i : act_q;
   assign pwm_o = (tb_o < eff);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q <= '0;
      else         act_q <= eff;
   end

   // R8: the active duty is held whenever the timebase is not at zero
   a_r8_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap |=> $stable(act_q));
endmodule

// File: rtl/pwm2_gen.sv
module pwm2_gen
   import pwm2_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DUTY_W      = 8,
   parameter int SLOW_LSB    = 7,
   parameter int PRE_STAGES  = 7,
   parameter int SYNC_STAGES = 2,
   parameter int BE_W        = CNT_W / LANE_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ext_clk_i,
   input  logic             frz_i,
   input  logic [1:0]       bus_addr_i,
   input  logic             bus_wr_i,
   input  logic [BE_W-1:0]  bus_be_i,
   input  logic [CNT_W-1:0] bus_wdata_i,
   output logic [CNT_W-1:0] bus_rdata_o,
   output logic             pwm_a_o,
   output logic             pwm_b_o
);
   localparam int N_CH   = 2;
   localparam int SEL_W  = $clog2(PRE_STAGES + 1);
   localparam int DW2    = N_CH * DUTY_W;
   localparam int CTRL_W = N_CH + SEL_W;
   localparam int TB_W   = SLOW_LSB + DUTY_W;

   if (CNT_W % LANE_W != 0) begin : g_bad_lane
      $error("pwm2_gen: counter width must be whole bytes");
   end
   if (DW2 > CNT_W || TB_W > CNT_W || CTRL_W > LANE_W) begin : g_bad_fit
      $error("pwm2_gen: fields do not fit the bus word");
   end

   pwm2_addr_e        addr;
   logic [CNT_W-1:0]  be_mask;
   logic [CNT_W-1:0]  cnt_q;
   logic [DW2-1:0]    duty_q;
   logic [N_CH-1:0]   slow_q;
   logic [SEL_W-1:0]  sel_q;
   logic              tick;
   logic              cnt_we, duty_we, ctrl_we;
   logic [DUTY_W-1:0] tb  [N_CH];
   logic [N_CH-1:0]   pwm;

   assign addr = pwm2_addr_e'(bus_addr_i);

   for (genvar b = 0; b < BE_W; b++) begin : g_mask
      assign be_mask[b*LANE_W +: LANE_W] = {LANE_W{bus_be_i[b]}};
   end

   assign cnt_we  = bus_wr_i && frz_i && (addr == ADR_CNT);
   assign duty_we = bus_wr_i && (addr == ADR_DUTY);
   assign ctrl_we = bus_wr_i && (addr == ADR_CTRL) && bus_be_i[0];

   pwm2_tick #(
      .PRE_STAGES (PRE_STAGES),
      .SYNC_STAGES(SYNC_STAGES),
      .SEL_W      (SEL_W)
   ) u_tick (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sel_i (sel_q),
      .ext_i (ext_clk_i),
      .tick_o(tick)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         duty_q <= '0;
         slow_q <= '0;
         sel_q  <= '0;
      end else begin
         if (cnt_we)    cnt_q <= (cnt_q & ~be_mask) | (bus_wdata_i & be_mask);
         else if (tick) cnt_q <= cnt_q + 1'b1;
         if (duty_we)
            duty_q <= (duty_q & ~be_mask[DW2-1:0]) | (bus_wdata_i[DW2-1:0] & be_mask[DW2-1:0]);
         if (ctrl_we) begin
            slow_q <= bus_wdata_i[N_CH-1:0];
            sel_q  <= bus_wdata_i[CTRL_W-1:N_CH];
         end
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      unique case (addr)
         ADR_CNT:  bus_rdata_o = cnt_q;
         ADR_DUTY: bus_rdata_o[DW2-1:0] = duty_q;
         ADR_CTRL: bus_rdata_o[CTRL_W-1:0] = {sel_q, slow_q};
         default:  bus_rdata_o = '0;
      endcase
   end

   // channel 0 (A) owns the upper duty byte, channel 1 (B) the lower one
   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      pwm2_chan #(
         .DUTY_W  (DUTY_W),
         .SLOW_LSB(SLOW_LSB)
      ) u_chan (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .cnt_i (cnt_q[TB_W-1:0]),
         .slow_i(slow_q[c]),
         .duty_i(duty_q[(N_CH-1-c)*DUTY_W +: DUTY_W]),
         .tb_o  (tb[c]),
         .pwm_o (pwm[c])
      );

      // R7: a zero duty gives a low pin at the period start
      a_r7_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (duty_q[(N_CH-1-c)*DUTY_W +: DUTY_W] == '0 && tb[c] == '0) |-> !pwm[c]);

      // R8: without a load or a mode change, a pin rises only at wrap
      a_r8_rise_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($rose(pwm[c]) && !$past(cnt_we) && $stable(slow_q)) |-> (tb[c] == '0));
   end

   assign pwm_a_o = pwm[0];
   assign pwm_b_o = pwm[1];

   // R10: outside a freeze load the counter holds or steps by one
   a_r10_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/test_pwm2_gen.sv
module test_pwm2_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk = 1'b0;
   logic        frz = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic        wr = 1'b0;
   logic [1:0]  be = 2'b00;
   logic [15:0] wdata = 16'h0;
   logic [15:0] rdata;
   logic        pwm_a, pwm_b;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] pend_a = 8'h00, pend_b = 8'h00;
   logic [7:0] act_a = 8'h00, act_b = 8'h00;
   logic       slow_a = 1'b0, slow_b = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm2_gen i_pwm2_gen (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .ext_clk_i  (ext_clk),
      .frz_i      (frz),
      .bus_addr_i (addr),
      .bus_wr_i   (wr),
      .bus_be_i   (be),
      .bus_wdata_i(wdata),
      .bus_rdata_o(rdata),
      .pwm_a_o    (pwm_a),
      .pwm_b_o    (pwm_b)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [1:0] b, input logic [15:0] d);
      @(negedge clk);
      addr = a; be = b; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; addr = 2'd0; be = 2'b00;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [15:0] v);
      addr = a;
      #1;
      v = rdata;
      addr = 2'd0;
   endtask

   task automatic set_duty(input logic [7:0] a, input logic [7:0] b);
      bus_wr(2'd1, 2'b11, {a, b});
      pend_a = a; pend_b = b;
   endtask

   task automatic set_ctrl(input logic sa, input logic sb, input logic [2:0] ps);
      bus_wr(2'd2, 2'b01, {11'd0, ps, sb, sa});
      slow_a = sa; slow_b = sb;
   endtask

   task automatic load_cnt(input logic [15:0] v);
      frz = 1'b1;
      bus_wr(2'd0, 2'b11, v);
      frz = 1'b0;
   endtask

   // arithmetic model of both pins, one comparison per channel per cycle
   task automatic run_cmp(input int n, input logic [7:0] stop_tb_a, input bit use_stop);
      for (int i = 0; i < n; i++) begin
         logic [15:0] c;
         logic [7:0]  ta, tbv;
         @(negedge clk);
         bus_rd(2'd0, c);
         ta  = slow_a ? c[14:7] : c[7:0];
         tbv = slow_b ? c[14:7] : c[7:0];
         if (ta == 8'h00)  act_a = pend_a;
         if (tbv == 8'h00) act_b = pend_b;
         chk(pwm_a == (ta < act_a), slow_a ? "R6 pin A" : "R5 pin A", pwm_a, ta < act_a);
         chk(pwm_b == (tbv < act_b), slow_b ? "R6 pin B" : "R5 pin B", pwm_b, tbv < act_b);
         if (use_stop && ta == stop_tb_a) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] v, c0, c1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      bus_rd(2'd0, v); chk(v == 16'h0, "R1 counter", v, 0);
      bus_rd(2'd1, v); chk(v == 16'h0, "R1 duty", v, 0);
      bus_rd(2'd2, v); chk(v == 16'h0, "R1 control", v, 0);
      chk(pwm_a == 1'b0 && pwm_b == 1'b0, "R1 pins", {pwm_a, pwm_b}, 0);

      // R2 default rate
      bus_rd(2'd0, c0);
      repeat (100) @(negedge clk);
      bus_rd(2'd0, c1);
      chk(c1 - c0 == 16'd50, "R2 default rate", c1 - c0, 50);

      // R3 prescaler codes
      for (int k = 0; k < 7; k++) begin
         set_ctrl(1'b0, 1'b0, 3'(k));
         bus_rd(2'd0, c0);
         repeat (256) @(negedge clk);
         bus_rd(2'd0, c1);
         chk(c1 - c0 == 16'(256 >> (k + 1)), "R3 prescaler rate", c1 - c0, 256 >> (k + 1));
      end

      // R11 control readback and empty address
      set_ctrl(1'b1, 1'b0, 3'd7);
      bus_rd(2'd2, v); chk(v == 16'h001D, "R11 control readback", v, 16'h001D);
      bus_rd(2'd3, v); chk(v == 16'h0000, "R11 empty address", v, 0);

      // R10 counter reads and freeze-gated loads (counter idle on external input)
      bus_rd(2'd0, c0);
      repeat (4) @(negedge clk);
      bus_rd(2'd0, c1);
      chk(c1 == c0, "R10 read does not disturb", c1, c0);
      bus_wr(2'd0, 2'b11, 16'h1234);
      bus_rd(2'd0, v); chk(v == c0, "R10 write ignored without freeze", v, c0);
      load_cnt(16'h3F00);
      bus_rd(2'd0, v); chk(v == 16'h3F00, "R10 freeze load", v, 16'h3F00);
      frz = 1'b1;
      bus_wr(2'd0, 2'b01, 16'hAB11);
      frz = 1'b0;
      bus_rd(2'd0, v); chk(v == 16'h3F11, "R10 byte load", v, 16'h3F11);

      // R4 external clock edges
      for (int p = 0; p < 5; p++) begin
         ext_clk = 1'b1; repeat (4) @(negedge clk);
         ext_clk = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      bus_rd(2'd0, v); chk(v == 16'h3F16, "R4 external count", v, 16'h3F16);
      ext_clk = 1'b1; repeat (2) @(negedge clk);
      bus_rd(2'd0, v); chk(v == 16'h3F16, "R4 sync latency", v, 16'h3F16);
      repeat (2) @(negedge clk);
      bus_rd(2'd0, v); chk(v == 16'h3F17, "R4 counted after sync", v, 16'h3F17);
      ext_clk = 1'b0;

      // R5, R7: fast mode sweep over duty values
      set_ctrl(1'b0, 1'b0, 3'd0);
      begin
         logic [7:0] da [6] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h37, 8'hC8};
         logic [7:0] db [6] = '{8'hFF, 8'h00, 8'h01, 8'h80, 8'hC8, 8'h37};
         for (int i = 0; i < 6; i++) begin
            set_duty(da[i], db[i]);
            run_cmp(600, 8'h00, 1'b0);
         end
      end
      // R7 explicit extremes at known timebase values
      set_duty(8'h00, 8'hFF);
      run_cmp(600, 8'hFF, 1'b1);
      chk(pwm_a == 1'b0, "R7 zero duty low", pwm_a, 0);
      chk(pwm_b == 1'b0, "R7 full duty low at 0xFF", pwm_b, 0);
      run_cmp(600, 8'hFE, 1'b1);
      chk(pwm_b == 1'b1, "R7 full duty high at 0xFE", pwm_b, 1);

      // R6 slow mode on A, fast on B, then swapped
      set_ctrl(1'b1, 1'b0, 3'd0);
      set_duty(8'h03, 8'h80);
      load_cnt(16'h7F00);
      run_cmp(3000, 8'h00, 1'b0);
      set_ctrl(1'b0, 1'b1, 3'd0);
      set_duty(8'h40, 8'h02);
      load_cnt(16'h7F00);
      run_cmp(3000, 8'h00, 1'b0);

      // R8 deferred duty update
      set_ctrl(1'b0, 1'b0, 3'd0);
      set_duty(8'h80, 8'h80);
      run_cmp(600, 8'h40, 1'b1);
      bus_wr(2'd1, 2'b10, 16'h1000);
      pend_a = 8'h10;
      #1;
      chk(pwm_a == 1'b1, "R8 old duty kept mid-period", pwm_a, 1);
      run_cmp(600, 8'h00, 1'b0);

      // R9 byte lanes of the duty word
      bus_wr(2'd1, 2'b01, 16'hAA55);
      pend_b = 8'h55;
      bus_rd(2'd1, v); chk(v == 16'h1055, "R9 lower byte only", v, 16'h1055);
      bus_wr(2'd1, 2'b10, 16'h6677);
      pend_a = 8'h66;
      bus_rd(2'd1, v); chk(v == 16'h6655, "R9 upper byte only", v, 16'h6655);
      run_cmp(600, 8'h00, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule